// File: doc/BRIEF.md
# BCD Count-Up Timer with Match

This block is a minutes-and-seconds timer that counts upward from 00:00 in binary-coded decimal. It stops when its count equals a target time read from a 14-bit switch word. Each of the four digits is shown as a binary-clock column with row weights 8, 4, 2 and 1, so the digit's value is the sum of its lit rows. The block also echoes the target digits, after clamping, on a second 14-bit output so that they can light a second array.

The count moves forward by one second on each clock cycle in which the one-second `tick` enable is high. Equality with the target is checked every cycle and recorded in a register. One clock after the count reaches the target, `done` rises and the count freezes. While `done` is set, every display output is forced on: all four counting columns show 1111 and the target echo shows all ones. The flag stays set until a synchronous reset or a `start` pulse clears it. Every pin is a plain level signal, so there is no valid/ready handshake and no back-pressure.

Top module: `bcd_upcount_timer`

## Requirements
- R1: The target bits are laid out as follows: [3:0] seconds ones, [6:4] seconds tens, [10:7] minutes ones, [13:11] minutes tens. A ones digit above 9 is clamped to 9 and a tens digit above 5 is clamped to 5 before comparison. While `done` is low, `target_echo` shows the clamped digits in the same bit layout.
- R2: When `rst_n` is low or `start` is high at a rising edge, the count becomes 00:00 and `done` becomes 0 at that edge. Reset and start take priority over a `tick` in the same cycle.
- R3: The count changes only at an edge where `tick` is high, and it moves forward by exactly one second per such edge.
- R4: Seconds ones rolls from 9 to 0 and carries into seconds tens. Seconds tens rolls from 5 to 0 and carries into minutes ones.
- R5: Minutes ones rolls from 9 to 0 and carries into minutes tens.
- R6: At 59:59 a tick leaves the count unchanged.
- R7: `done` rises at the first edge after the edge at which the count became equal to the target. A tick in the cycle where the count equals the target does not advance the count.
- R8: While `done` is high, ticks do not change the count, and `done` stays high, even if the target changes, until reset or start.
- R9: With a target of 00:00, `done` rises at the first edge after reset is released, and no counting takes place.
- R10: While `done` is high, all four column outputs read 4'b1111 and `target_echo` reads all ones. Otherwise each column carries its count digit, with each tens digit zero-extended to 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Synchronous restart: clears the count and `done` |
| tick | input | 1 | One-second advance enable |
| target | input | 14 | Target time as four BCD digits (layout in R1) |
| col_min_tens | output | 4 | Minutes-tens column, rows weighted 8/4/2/1 |
| col_min_ones | output | 4 | Minutes-ones column |
| col_sec_tens | output | 4 | Seconds-tens column |
| col_sec_ones | output | 4 | Seconds-ones column |
| target_echo | output | 14 | Clamped target digits, or all ones when done |
| done | output | 1 | Time-up flag; stays set until reset or start |

## Verification
Two of the block's actions can land on the same edge. A tick can arrive in the cycle in which the count first equals the target, where it must be dropped rather than carried past the match. A start pulse can coincide with a tick, where the clear must win. The bench creates both by holding `tick` high without a break through a short match and by raising `start` together with `tick`. It compares every output against a seconds-based reference model on each clock and flags any overshoot by one second or any count left non-zero.

// File: rtl/bcd_timer_pkg.sv
package bcd_timer_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int DIG_W      = 4;
  localparam int ONES_TW    = 4;
  localparam int TENS_TW    = 3;
  localparam int PAIR_TW    = ONES_TW + TENS_TW;
  localparam int TGT_W      = 2 * PAIR_TW;

  localparam logic [DIG_W-1:0] ONES_MAX = 4'd9;
  localparam logic [DIG_W-1:0] TENS_MAX = 4'd5;

  typedef logic [NUM_DIGITS-1:0][DIG_W-1:0] digit_vec_t;

  // digit index: 0 sec ones, 1 sec tens, 2 min ones, 3 min tens
  function automatic int field_off(int i);
    return (i / 2) * PAIR_TW + (i % 2) * ONES_TW;
  endfunction

  function automatic int field_w(int i);
    return (i % 2 == 1) ? TENS_TW : ONES_TW;
  endfunction

  function automatic logic [DIG_W-1:0] digit_max(int i);
    return (i % 2 == 1) ? TENS_MAX : ONES_MAX;
  endfunction
endpackage

// File: rtl/bcd_target_clamp.sv
module bcd_target_clamp
  import bcd_timer_pkg::*;
(
  input  logic [TGT_W-1:0] target_raw,
  output digit_vec_t       tgt_digits
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_field
    localparam int          OFF  = field_off(i);
    localparam int          W    = field_w(i);
    localparam logic [DIG_W-1:0] LIM = digit_max(i);
    logic [W-1:0]     raw;
    logic [DIG_W-1:0] wide;
    assign raw  = target_raw[OFF +: W];
    assign wide = DIG_W'(raw);
    assign tgt_digits[i] = (wide > LIM) ? LIM : wide;
  end
endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell #(
  parameter int               W         = 4,
  parameter logic [W-1:0]     MAX       = 4'd9,
  parameter bit               SATURATE  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      q <= '0;
    end else if (step) begin
      if (q == MAX) q <= SATURATE ? q : '0;
      else          q <= q + W'(1);
    end
  end
endmodule

// File: rtl/bcd_match_reg.sv
module bcd_match_reg
  import bcd_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  digit_vec_t count_digits,
  input  digit_vec_t tgt_digits,
  output logic       equal_now,
  output logic       done
);
  assign equal_now = (count_digits == tgt_digits);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) done <= 1'b0;
    else if (equal_now)  done <= 1'b1;
  end
endmodule

// File: rtl/bcd_display_mux.sv
module bcd_display_mux
  import bcd_timer_pkg::*;
(
  input  logic             done,
  input  digit_vec_t       count_digits,
  input  digit_vec_t       tgt_digits,
  output digit_vec_t       columns,
  output logic [TGT_W-1:0] echo
);
  logic [TGT_W-1:0] packed_tgt;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_pack
    localparam int OFF = field_off(i);
    localparam int W   = field_w(i);
    assign packed_tgt[OFF +: W] = tgt_digits[i][W-1:0];
    assign columns[i] = done ? {DIG_W{1'b1}} : count_digits[i];
  end

  assign echo = done ? {TGT_W{1'b1}} : packed_tgt;
endmodule

// File: rtl/bcd_upcount_timer.sv
module bcd_upcount_timer
  import bcd_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [TGT_W-1:0] target,
  output logic [DIG_W-1:0] col_min_tens,
  output logic [DIG_W-1:0] col_min_ones,
  output logic [DIG_W-1:0] col_sec_tens,
  output logic [DIG_W-1:0] col_sec_ones,
  output logic [TGT_W-1:0] target_echo,
  output logic             done
);
  digit_vec_t            tgt_digits;
  digit_vec_t            count_q;
  digit_vec_t            columns;
  logic [NUM_DIGITS-1:0] step;
  logic [NUM_DIGITS-1:0] at_max;
  logic                  equal_now;
  logic                  hold;

  bcd_target_clamp u_clamp (
    .target_raw (target),
    .tgt_digits (tgt_digits)
  );

  assign hold    = equal_now || done || (&at_max);
  assign step[0] = tick && !hold;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign at_max[i] = (count_q[i] == digit_max(i));
    bcd_digit_cell #(
      .W        (DIG_W),
      .MAX      (digit_max(i)),
      .SATURATE (i == NUM_DIGITS - 1)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .step  (step[i]),
      .q     (count_q[i])
    );
    if (i < NUM_DIGITS - 1) begin : g_carry
      assign step[i+1] = step[i] && at_max[i];
    end
  end

  bcd_match_reg u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (start),
    .count_digits (count_q),
    .tgt_digits   (tgt_digits),
    .equal_now    (equal_now),
    .done         (done)
  );

  bcd_display_mux u_disp (
    .done         (done),
    .count_digits (count_q),
    .tgt_digits   (tgt_digits),
    .columns      (columns),
    .echo         (target_echo)
  );

  assign col_sec_ones = columns[0];
  assign col_sec_tens = columns[1];
  assign col_min_ones = columns[2];
  assign col_min_tens = columns[3];
endmodule

// File: rtl/bcd_upcount_timer_chk.sv
module bcd_upcount_timer_chk
  import bcd_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             tick,
  input logic             done,
  input digit_vec_t       count_q,
  input logic [DIG_W-1:0] col_min_tens,
  input logic [DIG_W-1:0] col_min_ones,
  input logic [DIG_W-1:0] col_sec_tens,
  input logic [DIG_W-1:0] col_sec_ones,
  input logic [TGT_W-1:0] target_echo
);
  AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q[0] <= 4'd9) && (count_q[1] <= 4'd5) && (count_q[2] <= 4'd9) && (count_q[3] <= 4'd5)); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count_q == '0) && !done); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !start |=> $stable(count_q)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(count_q)); // R8
  AST_DONE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&{col_min_tens, col_min_ones, col_sec_tens, col_sec_ones}) && (&target_echo)); // R10
endmodule

bind bcd_upcount_timer bcd_upcount_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .tick         (tick),
  .done         (done),
  .count_q      (count_q),
  .col_min_tens (col_min_tens),
  .col_min_ones (col_min_ones),
  .col_sec_tens (col_sec_tens),
  .col_sec_ones (col_sec_ones),
  .target_echo  (target_echo)
);

// File: tb/bcd_upcount_timer_bench.sv
module bcd_upcount_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        tick = 1'b0;
  logic [13:0] target = '0;
  logic [3:0]  col_min_tens, col_min_ones, col_sec_tens, col_sec_ones;
  logic [13:0] target_echo;
  logic        done;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  bit    checking = 1'b0;
  bit    finished = 1'b0;
  string tag = "R2";

  // reference model state: elapsed seconds and time-up flag
  int m_t = 0;
  bit m_done = 1'b0;

  always #10 clk = ~clk;

  bcd_upcount_timer u_bcd_upcount_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .target(target),
    .col_min_tens(col_min_tens), .col_min_ones(col_min_ones),
    .col_sec_tens(col_sec_tens), .col_sec_ones(col_sec_ones),
    .target_echo(target_echo), .done(done)
  );

  function automatic int lim(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic int tgt_secs(logic [13:0] t);
    int so = lim(int'(t[3:0]), 9);
    int st = lim(int'(t[6:4]), 5);
    int mo = lim(int'(t[10:7]), 9);
    int mt = lim(int'(t[13:11]), 5);
    return mt * 600 + mo * 60 + st * 10 + so;
  endfunction

  function automatic logic [13:0] tgt_echo_exp(logic [13:0] t);
    logic [13:0] e;
    e[3:0]   = 4'(lim(int'(t[3:0]), 9));
    e[6:4]   = 3'(lim(int'(t[6:4]), 5));
    e[10:7]  = 4'(lim(int'(t[10:7]), 9));
    e[13:11] = 3'(lim(int'(t[13:11]), 5));
    return e;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || start) begin
      m_t    <= 0;
      m_done <= 1'b0;
    end else begin
      if (m_t == tgt_secs(target)) m_done <= 1'b1;
      if (tick && !m_done && m_t != tgt_secs(target) && m_t != 3599) m_t <= m_t + 1;
    end
  end

  task automatic check_one(string what, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    logic [15:0] exp_cols;
    logic [13:0] exp_echo;
    if (!checking) return;
    compared++;
    if (m_done) begin
      exp_cols = 16'hFFFF;
      exp_echo = 14'h3FFF;
    end else begin
      exp_cols = {4'(m_t / 600), 4'((m_t / 60) % 10), 4'((m_t % 60) / 10), 4'(m_t % 10)};
      exp_echo = tgt_echo_exp(target);
    end
    check_one("columns", {col_min_tens, col_min_ones, col_sec_tens, col_sec_ones}, exp_cols);
    check_one("echo", {2'b00, target_echo}, {2'b00, exp_echo});
    check_one("done", {15'd0, done}, {15'd0, m_done});
  endtask

  task automatic cycle(bit t, bit s);
    @(negedge clk);
    compare();
    tick  = t;
    start = s;
  endtask

  task automatic run(int n, int period);
    for (int k = 0; k < n; k++) cycle((k % period) == 0, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // R2: reset state, checked while reset is held
    @(negedge clk);
    @(negedge clk);
    checking = 1'b1;
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);

    // R9: target 00:00 gives done right after reset release, no counting
    tag = "R9";
    rst_n = 1'b1;
    run(6, 1);

    // R3 and R7: target 01:12, ticks every third cycle
    tag = "R3 R7";
    target = {3'd0, 4'd1, 3'd1, 4'd2};
    cycle(1'b0, 1'b1);
    run(260, 3);

    // R8 and R10: target moved after done, done stays and display stays all on
    tag = "R8 R10";
    target = {3'd0, 4'd0, 3'd0, 4'd3};
    run(12, 1);

    // R1: illegal digits clamp to 59:59, echo shows clamped digits
    tag = "R1";
    target = {3'd7, 4'd15, 3'd7, 4'd15};
    cycle(1'b0, 1'b1);
    run(40, 1);

    // R4, R5, R6: target moved behind the count, count rolls through and holds at 59:59
    tag = "R4 R5 R6";
    target = {3'd0, 4'd0, 3'd1, 4'd0};
    run(3620, 1);

    // R7 and R2: start coincides with tick, then unbroken ticks into a short match
    tag = "R7 R2";
    target = {3'd0, 4'd0, 3'd0, 4'd5};
    cycle(1'b1, 1'b1);
    run(12, 1);

    // R2: reset in the middle of a run
    tag = "R2";
    target = {3'd0, 4'd2, 3'd0, 4'd0};
    cycle(1'b0, 1'b1);
    run(30, 1);
    rst_n = 1'b0;
    run(3, 1);
    rst_n = 1'b1;
    run(20, 1);

    cycle(1'b0, 1'b0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule